// File: doc/BRIEF.md
# Prioritized Interrupt Request Core

This block takes a set of interrupt request lines and holds each new request in a request register. It filters those requests through a software-written mask and picks one winner by fixed priority. When that winner may preempt the service already in progress, it raises a single interrupt line toward the processor. Line 0 has the highest priority and line `NLINES-1` the lowest.

The processor answers with an acknowledge-commit strobe. On that strobe the winning request leaves the request register and enters the in-service register. Service ends in one of two ways. In command mode, an end-of-interrupt strobe retires the most urgent in-service level. In automatic mode, the in-service bit is never kept. All three registers can be read back at all times.

Nesting follows from the in-service register. A request can interrupt only when its level is strictly more urgent than every level now in service. A masked level keeps its request recorded, and it never stops less urgent unmasked levels from being served.

Top module: `irq_prio_core`

## Requirements
- R1: After a synchronous active-low reset, the request and in-service registers read all zeros, the mask reads all ones, and `int_req` is low.
- R2: A low-to-high transition on a request line sets that line's request bit, also when the line is masked. A line that stays high does not set its bit again after the bit has been cleared. The line's level one cycle earlier is compared, and that earlier level is taken as zero right after reset.
- R3: A mask bit of 1 hides the matching request bit from selection. Masking one level does not stop any less urgent unmasked level from being selected.
- R4: Among pending unmasked requests, the lowest-numbered line wins. An acknowledge commit in command mode (`auto_eoi`=0) clears the winner's request bit and sets the same bit in the in-service register.
- R5: `int_req` is high only when the winner's line number is lower than the lowest-numbered in-service bit, or when no in-service bit is set.
- R6: With `int_req` low, an acknowledge commit changes neither the request register nor the in-service register.
- R7: In automatic mode (`auto_eoi`=1), an acknowledge commit clears the winner's request bit and leaves the in-service register unchanged.
- R8: An end-of-interrupt strobe clears only the lowest-numbered set in-service bit. It has no effect when the in-service register is empty.
- R9: A mask write replaces the whole mask with `mask_data` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NLINES | Request lines; a rising level records a request |
| mask_wr | input | 1 | Mask write enable |
| mask_data | input | NLINES | New mask value, 1 = masked |
| ack_commit | input | 1 | Acknowledge commit strobe |
| eoi_cmd | input | 1 | End-of-interrupt strobe (non-specific) |
| auto_eoi | input | 1 | 1 = automatic end of interrupt |
| int_req | output | 1 | Interrupt request to the processor |
| req_rd | output | NLINES | Request register readback |
| inserv_rd | output | NLINES | In-service register readback |
| mask_rd | output | NLINES | Mask register readback |

## Verification
The bench holds a request line high across its own acknowledge. A design that reacts to levels rather than edges would record the request again and raise `int_req` a second time.

It masks a high level while a lower level is also pending. A resolver that stops at the first set bit before the mask is applied would never serve the lower level.

It raises a less urgent line while a more urgent level is in service, and then a more urgent one. A design that ignores nesting would interrupt at the wrong time, and one that compares with "equal or lower" would preempt itself. Acknowledges with nothing eligible and end-of-interrupt strobes on an empty in-service register must change nothing. A design that commits anyway would corrupt the registers.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;

    typedef enum logic {
        EOI_BY_CMD  = 1'b0,
        EOI_BY_AUTO = 1'b1
    } eoi_mode_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority finder: lowest set index wins.
module irq_prio_pick #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        hit_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                hit_o    = '0;
                hit_o[i] = 1'b1;
                idx_o    = IDX_W'(i);
                any_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_nest_gate.sv
// Decides whether the best pending level may preempt current service.
module irq_nest_gate #(
    parameter int IDX_W = 3
) (
    input  logic             req_any_i,
    input  logic [IDX_W-1:0] req_idx_i,
    input  logic             svc_any_i,
    input  logic [IDX_W-1:0] svc_idx_i,
    output logic             grant_o
);

    always_comb begin
        grant_o = req_any_i && (!svc_any_i || (req_idx_i < svc_idx_i));
    end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_core_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              mask_wr,
    input  logic [NLINES-1:0] mask_data,
    input  logic              ack_commit,
    input  logic              eoi_cmd,
    input  logic              auto_eoi,
    output logic              int_req,
    output logic [NLINES-1:0] req_rd,
    output logic [NLINES-1:0] inserv_rd,
    output logic [NLINES-1:0] mask_rd
);

    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    typedef struct packed {
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] irr;
        logic [NLINES-1:0] isr;
        logic [NLINES-1:0] imr;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [NLINES-1:0] pending;
    logic [NLINES-1:0] win_oh;
    logic [IDX_W-1:0]  win_idx;
    logic              win_any;
    logic [NLINES-1:0] top_svc_oh;
    logic [IDX_W-1:0]  top_svc_idx;
    logic              svc_any;
    logic              eligible;
    eoi_mode_e         mode;

    assign pending = st_q.irr & ~st_q.imr;
    assign mode    = auto_eoi ? EOI_BY_AUTO : EOI_BY_CMD;

    irq_prio_pick #(.WIDTH(NLINES)) u_req_pick (
        .vec_i (pending),
        .hit_o (win_oh),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    irq_prio_pick #(.WIDTH(NLINES)) u_svc_pick (
        .vec_i (st_q.isr),
        .hit_o (top_svc_oh),
        .idx_o (top_svc_idx),
        .any_o (svc_any)
    );

    irq_nest_gate #(.IDX_W(IDX_W)) u_gate (
        .req_any_i (win_any),
        .req_idx_i (win_idx),
        .svc_any_i (svc_any),
        .svc_idx_i (top_svc_idx),
        .grant_o   (eligible)
    );

    always_comb begin
        logic [NLINES-1:0] rise;
        logic [NLINES-1:0] irr_clr;
        logic [NLINES-1:0] isr_clr;
        logic [NLINES-1:0] isr_set;
        logic              take;

        st_d    = st_q;
        rise    = irq_lines & ~st_q.prev;
        take    = ack_commit && eligible;
        irr_clr = take ? win_oh : '0;
        isr_clr = eoi_cmd ? top_svc_oh : '0;
        isr_set = (take && mode == EOI_BY_CMD) ? win_oh : '0;

        st_d.prev = irq_lines;
        st_d.irr  = (st_q.irr & ~irr_clr) | rise;
        st_d.isr  = (st_q.isr & ~isr_clr) | isr_set;
        if (mask_wr) begin
            st_d.imr = mask_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.irr  <= '0;
            st_q.isr  <= '0;
            st_q.imr  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_req   = eligible;
    assign req_rd    = st_q.irr;
    assign inserv_rd = st_q.isr;
    assign mask_rd   = st_q.imr;

    // R5: an interrupt request needs a pending unmasked bit behind it
    a_r5_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (|(st_q.irr & ~st_q.imr)));

    // R4: the resolver never names two winners
    a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh));

    // R4: a command-mode commit adds exactly one in-service bit
    a_r4_commit_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_commit && int_req && !auto_eoi && !eoi_cmd) |=>
            ($countones(st_q.isr) == $past($countones(st_q.isr)) + 1));

    // R6: a commit with nothing eligible leaves service untouched
    a_r6_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_commit && !int_req && !eoi_cmd) |=> $stable(st_q.isr));

    // R7: an automatic-mode commit leaves service untouched
    a_r7_auto_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_commit && auto_eoi && !eoi_cmd) |=> $stable(st_q.isr));

    // R8: one end-of-interrupt retires exactly one level
    a_r8_eoi_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !ack_commit && (st_q.isr != '0)) |=>
            ($countones(st_q.isr) == $past($countones(st_q.isr)) - 1));

    // R9: a mask write lands on the next edge
    a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_rd == $past(mask_data)));

endmodule

// File: tb/tb_irq_prio_core.sv
module tb_irq_prio_core;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_lines;
    logic         mask_wr;
    logic [N-1:0] mask_data;
    logic         ack_commit;
    logic         eoi_cmd;
    logic         auto_eoi;
    logic         int_req;
    logic [N-1:0] req_rd;
    logic [N-1:0] inserv_rd;
    logic [N-1:0] mask_rd;

    always #5 clk = ~clk;

    irq_prio_core #(.NLINES(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .mask_wr    (mask_wr),
        .mask_data  (mask_data),
        .ack_commit (ack_commit),
        .eoi_cmd    (eoi_cmd),
        .auto_eoi   (auto_eoi),
        .int_req    (int_req),
        .req_rd     (req_rd),
        .inserv_rd  (inserv_rd),
        .mask_rd    (mask_rd)
    );

    typedef struct {
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [N-1:0] imr;
        logic         intr;
        string        tag;
    } expect_t;

    expect_t exp_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference state
    logic [N-1:0] m_prev, m_irr, m_isr, m_imr;

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    function automatic logic m_elig();
        int w = lowest(m_irr & ~m_imr);
        int s = lowest(m_isr);
        return (w < N) && (w < s);
    endfunction

    task automatic compare(input expect_t e);
        n_checks++;
        if (req_rd !== e.irr || inserv_rd !== e.isr || mask_rd !== e.imr || int_req !== e.intr) begin
            n_fails++;
            $display("FAIL %s: got irr=%h isr=%h imr=%h int=%b, expected irr=%h isr=%h imr=%h int=%b",
                     e.tag, req_rd, inserv_rd, mask_rd, int_req, e.irr, e.isr, e.imr, e.intr);
        end
    endtask

    // driver: apply one cycle of stimulus and push the predicted state
    task automatic step(input logic [N-1:0] irq, input logic mwr, input logic [N-1:0] mdat,
                        input logic ack, input logic eoi, input logic aeoi, input string tag);
        expect_t e;
        logic [N-1:0] rise, win, top;
        logic take;
        @(negedge clk);
        irq_lines  = irq;
        mask_wr    = mwr;
        mask_data  = mdat;
        ack_commit = ack;
        eoi_cmd    = eoi;
        auto_eoi   = aeoi;
        rise = irq & ~m_prev;
        take = ack && m_elig();
        win  = '0;
        if (lowest(m_irr & ~m_imr) < N) win[lowest(m_irr & ~m_imr)] = 1'b1;
        top  = '0;
        if (lowest(m_isr) < N) top[lowest(m_isr)] = 1'b1;
        m_prev = irq;
        m_irr  = (m_irr & ~(take ? win : '0)) | rise;
        m_isr  = (m_isr & ~(eoi ? top : '0)) | ((take && !aeoi) ? win : '0);
        if (mwr) m_imr = mdat;
        e.irr  = m_irr;
        e.isr  = m_isr;
        e.imr  = m_imr;
        e.intr = m_elig();
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare after each edge that followed a driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        expect_t r;
        rst_n = 1'b0;
        irq_lines = '0; mask_wr = 0; mask_data = '0;
        ack_commit = 0; eoi_cmd = 0; auto_eoi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_prev = '0; m_irr = '0; m_isr = '0; m_imr = '1;
        // R1 reset state
        r.irr = '0; r.isr = '0; r.imr = '1; r.intr = 1'b0; r.tag = "R1 reset";
        compare(r);

        step(8'h04, 0, 8'h00, 0, 0, 0, "R2 masked edge recorded");
        step(8'h04, 1, 8'h00, 0, 0, 0, "R9 unmask raises int R3");
        step(8'h04, 0, 8'h00, 1, 0, 0, "R4 commit line2");
        step(8'h04, 0, 8'h00, 0, 0, 0, "R2 held line no re-set");
        step(8'h44, 0, 8'h00, 0, 0, 0, "R5 lower level blocked by service");
        step(8'h46, 0, 8'h00, 0, 0, 0, "R5 higher level preempts");
        step(8'h46, 0, 8'h00, 1, 0, 0, "R4 nested commit line1");
        step(8'h46, 0, 8'h00, 0, 1, 0, "R8 eoi clears line1 only");
        step(8'h46, 0, 8'h00, 0, 1, 0, "R8 eoi clears line2 R5");
        step(8'h00, 0, 8'h00, 0, 0, 0, "R2 lines drop");
        step(8'h09, 1, 8'h01, 0, 0, 0, "R3 masked line0 keeps bit");
        step(8'h09, 0, 8'h00, 1, 0, 0, "R3 lower level served past mask");
        step(8'h09, 0, 8'h00, 1, 0, 0, "R6 commit with nothing eligible");
        step(8'h09, 0, 8'h00, 0, 1, 0, "R8 eoi line3");
        step(8'h09, 0, 8'h00, 1, 0, 1, "R7 auto commit line6");
        step(8'h09, 0, 8'h00, 1, 0, 1, "R6 commit with none pending");
        step(8'h09, 0, 8'h00, 0, 1, 0, "R8 eoi on empty service");
        step(8'h09, 1, 8'hA5, 0, 0, 0, "R9 mask write pattern");
        step(8'h00, 0, 8'h00, 0, 0, 0, "R1 idle");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule